// File: doc/BRIEF.md
# Store-to-Store Hazard Interlock

This block watches the instruction sitting in the combined decode and operand-fetch stage of an in-order pipeline. It holds back an ordinary store that would reuse a shared store resource too early. When an ordinary store leaves its final cycle in that stage, the resource stays occupied for a fixed window of clock cycles. An ordinary store that shows up inside that window gets a stall signal until the window has run out.

Multiple-register move instructions use their own resources. They neither open the window nor wait on it. Non-store instructions and empty slots pass through untouched, and the window keeps draining while they do. Memory is assumed to answer with no wait states, so this block is the only source of stall it models. Decode, datapath and memory live elsewhere: the block only consumes four per-cycle flags and returns one stall line.

Top module: `store_hazard_interlock`

## Requirements
- R1: After the synchronous active-high reset, the window is closed, so the first ordinary store is never stalled. This holds even if a window was open when reset arrived.
- R2: An ordinary store (valid=1, store=1, multi=0, last=1) accepted in cycle t opens a window of WIN_CYCLES cycles. With the default of 2, an ordinary store arriving at t+1 is stalled for exactly 2 cycles and accepted at t+3.
- R3: An ordinary store arriving 2 cycles after the previous one was accepted is stalled for exactly 1 cycle.
- R4: An ordinary store arriving 3 or more cycles after the previous one was accepted is not stalled.
- R5: A multiple-register move (store=1, multi=1) is never stalled, even inside an open window.
- R6: A multiple-register move does not open a window. An ordinary store right after it is not stalled.
- R7: A non-store instruction (valid=1, store=0) is never stalled. The window keeps counting down while such instructions pass, so the sequence store, one non-store, store gives 1 stall cycle.
- R8: An empty slot (valid=0) is never stalled and opens no window, whatever its other flags are.
- R9: An ordinary store cycle with last=0 does not open a window. Only the final stage cycle of a store does.
- R10: A held store does not extend the window. The stall output is never high for more than WIN_CYCLES consecutive cycles.
- R11: The window is loaded again on the cycle a held ordinary store is finally accepted. A store right behind it is stalled for the full window again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ds_valid | input | 1 | Stage holds an instruction |
| ds_store | input | 1 | Instruction is a store |
| ds_multi | input | 1 | Instruction is a multiple-register move |
| ds_last | input | 1 | This is the instruction's final stage cycle |
| stall_o | output | 1 | Hold the stage this cycle |

## Verification
The bench aims at the off-by-one edges of the window. It sweeps issue gaps of 1, 2 and 3 cycles, which should give 2, 1 and 0 stall cycles. A counter that loads one too many or too few, or that starts counting a cycle late, shifts at least one of these counts. Moves that either stall or arm the window show up as stalls where none are expected. A design that freezes the count while a store is held stalls forever or for too long. A design that forgets to reload on the held store's acceptance leaves the store right behind it unstalled.

// File: rtl/sti_pkg.sv
package sti_pkg;
  localparam int unsigned DEFAULT_WIN = 2;

  typedef struct packed {
    logic valid;
    logic store;
    logic multi;
    logic last;
  } stage_t;
endpackage

// File: rtl/sti_classify.sv
module sti_classify
  import sti_pkg::*;
(
  input  stage_t ins,
  input  logic   busy,
  output logic   plain_store,
  output logic   stall,
  output logic   arm
);
  always_comb begin
    plain_store = ins.valid && ins.store && !ins.multi;
    stall       = plain_store && busy;
    arm         = plain_store && ins.last && !busy;
  end

  // R5: the move form must never be held
  always_comb begin
    if (ins.valid && ins.multi) assert_move_free_R5: assert (!stall);
  end
endmodule

// File: rtl/sti_window_ctr.sv
module sti_window_ctr #(
  parameter int unsigned WIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic busy
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LOADV = CW'(WIN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (arm)       cnt <= LOADV;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R7: the window drains by one each cycle unless armed
  assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !arm) |=> (cnt == $past(cnt) - 1'b1));
  // R2: arming always opens the window
  assert_armed_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> busy);
endmodule

// File: rtl/store_hazard_interlock.sv
module store_hazard_interlock
  import sti_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = DEFAULT_WIN
) (
  input  logic clk,
  input  logic rst,
  input  logic ds_valid,
  input  logic ds_store,
  input  logic ds_multi,
  input  logic ds_last,
  output logic stall_o
);
  localparam int unsigned RW = $clog2(WIN_CYCLES + 2) + 1;

  stage_t ins;
  logic   busy, plain_store, stall, arm;

  assign ins = '{valid: ds_valid, store: ds_store, multi: ds_multi, last: ds_last};

  sti_classify u_cls (
    .ins(ins), .busy(busy), .plain_store(plain_store), .stall(stall), .arm(arm)
  );

  sti_window_ctr #(.WIN(WIN_CYCLES)) u_win (
    .clk(clk), .rst(rst), .arm(arm), .busy(busy)
  );

  assign stall_o = stall;

  // checker state: length of the current stall run
  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (stall_o) run <= run + 1'b1;
    else              run <= '0;
  end

  // R10: no stall run longer than the window
  assert_stall_bound_R10: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (run < RW'(WIN_CYCLES)));
  // R1: first cycle after reset never stalls
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !stall_o);
  // R7: non-store instructions pass
  assert_nonstore_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (ds_valid && !ds_store) |-> !stall_o);
  // R8: empty slots pass
  assert_empty_pass_R8: assert property (@(posedge clk) disable iff (rst)
    !ds_valid |-> !stall_o);
  // R2: accepted ordinary final store blocks a store right behind it
  assert_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    (ds_valid && ds_store && !ds_multi && ds_last && !stall_o)
    |=> (!(ds_valid && ds_store && !ds_multi) || stall_o));
endmodule

// File: tb/store_hazard_interlock_tb.sv
module store_hazard_interlock_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 1'b0, s = 1'b0, m = 1'b0, l = 1'b0;
  logic stall;

  int checks = 0;
  int errors = 0;
  int busy_m = 0;   // reference: remaining window cycles
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_hazard_interlock u_dut (
    .clk(clk), .rst(rst), .ds_valid(v), .ds_store(s), .ds_multi(m),
    .ds_last(l), .stall_o(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare stall, update model at posedge
  task automatic step(input logic iv, is, im, il, output logic st);
    logic exp;
    string tag;
    @(negedge clk);
    v = iv; s = is; m = im; l = il;
    #1;
    exp = iv && is && !im && (busy_m > 0);
    if (!iv) tag = "R8"; else if (!is) tag = "R7"; else if (im) tag = "R5"; else tag = "R2";
    chk(tag, int'(stall), int'(exp));
    st = stall;
    @(posedge clk);
    if (rst) busy_m = 0;
    else if (iv && is && !im && il && !exp) busy_m = 2;
    else if (busy_m > 0) busy_m--;
  endtask

  // issue a single-cycle store, hold until accepted, return stall count
  task automatic issue(input logic im, output int n);
    logic st;
    n = 0;
    forever begin
      step(1'b1, 1'b1, im, 1'b1, st);
      if (!st) break;
      n++;
      if (n > 10) break;
    end
  endtask

  task automatic nops(input int k);
    logic st;
    for (int i = 0; i < k; i++) step(1'b1, 1'b0, 1'b0, 1'b1, st);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic st;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: first store after reset
    issue(1'b0, n); chk("R1", n, 0);
    // R2 / R3 / R4: issue gaps 1,2,3
    nops(4); issue(1'b0, n); issue(1'b0, n); chk("R2", n, 2);
    nops(4); issue(1'b0, n); nops(1); issue(1'b0, n); chk("R3", n, 1);
    nops(4); issue(1'b0, n); nops(2); issue(1'b0, n); chk("R4", n, 0);
    // R11: store right after a held store that was accepted
    issue(1'b0, n); chk("R11", n, 2);
    issue(1'b0, n); chk("R11", n, 2);
    // R5: move inside an open window
    nops(4); issue(1'b0, n); issue(1'b1, n); chk("R5", n, 0);
    // R6: move then ordinary store
    nops(4); issue(1'b1, n); issue(1'b0, n); chk("R6", n, 0);
    // R7: store, non-store, store -> 1 stall
    nops(4); issue(1'b0, n); nops(1); issue(1'b0, n); chk("R7", n, 1);
    // R8: empty slot with store flags inside window, then store at gap 3
    nops(4); issue(1'b0, n);
    step(1'b0, 1'b1, 1'b0, 1'b1, st); chk("R8", int'(st), 0);
    step(1'b0, 1'b1, 1'b0, 1'b1, st);
    issue(1'b0, n); chk("R8", n, 0);
    // R9: non-final store cycle opens no window
    nops(4); step(1'b1, 1'b1, 1'b0, 1'b0, st); chk("R9", int'(st), 0);
    issue(1'b0, n); chk("R9", n, 0);
    // R10: stall run never exceeds window length
    nops(4); issue(1'b0, n); issue(1'b0, n); chk("R10", int'(n <= 2), 1);
    // R1: reset clears an open window
    nops(4); issue(1'b0, n);
    @(negedge clk); rst = 1'b1; v = 1'b0;
    @(posedge clk); busy_m = 0;
    @(negedge clk); rst = 1'b0;
    issue(1'b0, n); chk("R1", n, 0);
    nops(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule